// File: doc/BRIEF.md
# Memory and Logic Power Controller

This block owns the two power-control bits of a programmable peripheral device. It turns them into standby enables for an embedded EPROM, an embedded SRAM and a programmable logic array. The processor reaches both bits through an I/O window. A power register at a fixed offset holds the active-low turbo bit, and a configuration register at a second offset holds the memory-miser bit. Each register is written on the clock edge after the write strobe and can be read back at any time.

Each array is split into an even half and an odd half, and each half has its own standby output. These outputs are derived from several inputs: the chip-select pin, or that pin's alternate role as a plain address input; the per-memory select strobes; the bus-width mode; and address bit 0. A separate output puts the logic array into zero-power mode while turbo is off. An input-activity detector watches a bus of monitored inputs. It raises a power-down flag only while the device is enabled, turbo is off and no monitored input changed since the last cycle.

Top module: `mem_logic_pwr_ctl`

## Requirements
- R1: A synchronous active-high reset sets turbo to on (stored bit 0) and miser to off. After reset the power register reads 8'hFE and the configuration register reads 8'h00.
- R2: A write that hits offset PWR_OFFSET (default 8'h10) while io_sel is high stores io_wdata bit 0 as the turbo bit, where 1 means turbo off. The new value shows on the edge after the strobe. Bits 7 to 1 of this register always read as 1.
- R3: The configuration register sits at offset CFG_OFFSET (default 8'h12). It keeps only the miser bit, in bit 3, and its other bits read as 0. A write to any other offset, or a write with io_sel low, changes neither register.
- R4: While the chip is disabled (cs_n high and cs_pin_is_addr low), all four standby outputs are 1, whatever the miser bit and the select strobes hold.
- R5: With miser off and the chip enabled, both EPROM halves are powered (standby 0), whether or not eprom_sel is high.
- R6: With miser on and the chip enabled, both EPROM halves are in standby while eprom_sel is low. This includes cycles in which sram_sel is high.
- R7: With miser on, byte_mode high and eprom_sel high, only one EPROM half is powered: the even half when addr0 is 0, the odd half when addr0 is 1. With byte_mode low, both halves are powered.
- R8: Both SRAM halves are in standby unless the chip is enabled and sram_sel is high. When the SRAM is selected, both halves are powered, except with miser on and byte_mode high, where the same addr0 half selection as R7 applies.
- R9: pla_zero_pwr equals the stored turbo bit: 1 while turbo is off, 0 while turbo is on.
- R10: With cs_pin_is_addr high, the chip counts as enabled whatever the level of cs_n.
- R11: pdown is 1 only when the chip is enabled, turbo is off and mon_in equals its value on the previous clock edge. A change of any monitored bit clears pdown for that cycle.
- R12: io_rdata is 0 when no read is active or the read offset matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Access falls inside the I/O window |
| io_addr | input | ADDR_W | Offset within the I/O window |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data |
| cs_n | input | 1 | Active-low chip select |
| cs_pin_is_addr | input | 1 | Chip-select pin used as an address or logic input |
| eprom_sel | input | 1 | EPROM access strobe |
| sram_sel | input | 1 | SRAM access strobe |
| byte_mode | input | 1 | 8-bit data bus mode |
| addr0 | input | 1 | Address bit 0, picks the array half |
| mon_in | input | MON_W | Monitored inputs for activity detection |
| eprom_stby_even | output | 1 | EPROM even half standby |
| eprom_stby_odd | output | 1 | EPROM odd half standby |
| sram_stby_even | output | 1 | SRAM even half standby |
| sram_stby_odd | output | 1 | SRAM odd half standby |
| pla_zero_pwr | output | 1 | Logic array in zero-power mode |
| pdown | output | 1 | Power-down flag |

## Verification
The hardest state to reach is pdown, because three conditions must hold together. Turbo must first be switched off through a bus write, the chip must be enabled, and mon_in must stay unchanged across a full clock edge. The stimulus writes the power register, holds the monitored inputs for a cycle, and then changes a single monitored bit. It samples in the cycle of the change and again in the cycle after it, which shows the one-cycle clear. Half-array gating is reached by writing the miser bit and then sweeping byte_mode, addr0 and both select strobes.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   localparam int TURBO_BIT = 0;   // active-low turbo in the power register
   localparam int MISER_BIT = 3;   // memory miser in the configuration register

   typedef struct packed {
      logic even;
      logic odd;
   } half_stby_t;
endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
   import pwr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PWR_OFFSET = 'h10,
   parameter logic [ADDR_W-1:0] CFG_OFFSET = 'h12
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              io_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              turbo_off,
   output logic              miser_on
);
   if (DATA_W <= MISER_BIT) begin : g_bad_width
      $error("pwr_regs: DATA_W too narrow for the miser bit");
   end
   if (PWR_OFFSET == CFG_OFFSET) begin : g_bad_offsets
      $error("pwr_regs: register offsets must differ");
   end

   logic pmr_hit, cfg_hit, pmr_wr, cfg_wr;
   logic unused_wdata;

   assign pmr_hit = io_sel && (io_addr == PWR_OFFSET);
   assign cfg_hit = io_sel && (io_addr == CFG_OFFSET);
   assign pmr_wr  = pmr_hit && io_wr;
   assign cfg_wr  = cfg_hit && io_wr;
   assign unused_wdata = ^io_wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         turbo_off <= 1'b0;
         miser_on  <= 1'b0;
      end else begin
         if (pmr_wr) turbo_off <= io_wdata[TURBO_BIT];
         if (cfg_wr) miser_on  <= io_wdata[MISER_BIT];
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_rd && pmr_hit) begin
         io_rdata            = '1;
         io_rdata[TURBO_BIT] = turbo_off;
      end else if (io_rd && cfg_hit) begin
         io_rdata[MISER_BIT] = miser_on;
      end
   end

   AST_RESET_VALUES: assert property (@(posedge clk)
      rst |=> (!turbo_off && !miser_on)); // R1
   AST_PMR_WRITE: assert property (@(posedge clk) disable iff (rst)
      pmr_wr |=> (turbo_off == $past(io_wdata[TURBO_BIT]))); // R2
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
      !(pmr_wr || cfg_wr) |=> ($stable(turbo_off) && $stable(miser_on))); // R3
   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(io_rd && (pmr_hit || cfg_hit)) |-> (io_rdata == '0)); // R12
endmodule

// File: rtl/mem_stby_gate.sv
module mem_stby_gate
   import pwr_pkg::*;
#(
   parameter bit IDLE_FOLLOWS_MISER = 1'b1  // 1: EPROM variant, 0: SRAM variant
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       chip_en,
   input  logic       miser_on,
   input  logic       sel,
   input  logic       byte_mode,
   input  logic       addr0,
   output half_stby_t stby
);
   logic powered, gate_half;

   if (IDLE_FOLLOWS_MISER) begin : g_eprom
      assign powered = chip_en && (sel || !miser_on);
      AST_MISER_OFF_POWERED: assert property (@(posedge clk) disable iff (rst)
         (chip_en && !miser_on) |-> (!stby.even && !stby.odd)); // R5
   end else begin : g_sram
      assign powered = chip_en && sel;
   end

   assign gate_half = sel && miser_on && byte_mode;
   assign stby.even = !powered || (gate_half && addr0);
   assign stby.odd  = !powered || (gate_half && !addr0);

   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
      !chip_en |-> (stby.even && stby.odd)); // R4
   AST_ONE_HALF_IN_BYTE_MODE: assert property (@(posedge clk) disable iff (rst)
      (chip_en && miser_on && byte_mode && sel) |->
         ($countones({stby.even, stby.odd}) == 1)); // R7
endmodule

// File: rtl/activity_det.sv
module activity_det #(
   parameter int MON_W = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [MON_W-1:0] mon_in,
   output logic             quiet
);
   logic [MON_W-1:0] mon_q;

   always_ff @(posedge clk) mon_q <= mon_in;

   assign quiet = (mon_q == mon_in);

   AST_CHANGE_NOT_QUIET: assert property (@(posedge clk) disable iff (rst)
      (mon_in != $past(mon_in)) |-> !quiet); // R11
endmodule

// File: rtl/mem_logic_pwr_ctl.sv
module mem_logic_pwr_ctl
   import pwr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int MON_W  = 16,
   parameter logic [ADDR_W-1:0] PWR_OFFSET = 'h10,
   parameter logic [ADDR_W-1:0] CFG_OFFSET = 'h12
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              io_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              cs_n,
   input  logic              cs_pin_is_addr,
   input  logic              eprom_sel,
   input  logic              sram_sel,
   input  logic              byte_mode,
   input  logic              addr0,
   input  logic [MON_W-1:0]  mon_in,
   output logic              eprom_stby_even,
   output logic              eprom_stby_odd,
   output logic              sram_stby_even,
   output logic              sram_stby_odd,
   output logic              pla_zero_pwr,
   output logic              pdown
);
   if (MON_W < 1) begin : g_bad_mon
      $error("mem_logic_pwr_ctl: MON_W must be at least 1");
   end

   logic turbo_off, miser_on, chip_en, quiet;
   half_stby_t ep_stby, sr_stby;

   assign chip_en = cs_pin_is_addr || !cs_n;

   pwr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PWR_OFFSET(PWR_OFFSET), .CFG_OFFSET(CFG_OFFSET)
   ) u_regs (
      .clk(clk), .rst(rst), .io_sel(io_sel), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .turbo_off(turbo_off), .miser_on(miser_on)
   );

   mem_stby_gate #(.IDLE_FOLLOWS_MISER(1'b1)) u_eprom (
      .clk(clk), .rst(rst), .chip_en(chip_en), .miser_on(miser_on),
      .sel(eprom_sel), .byte_mode(byte_mode), .addr0(addr0), .stby(ep_stby)
   );

   mem_stby_gate #(.IDLE_FOLLOWS_MISER(1'b0)) u_sram (
      .clk(clk), .rst(rst), .chip_en(chip_en), .miser_on(miser_on),
      .sel(sram_sel), .byte_mode(byte_mode), .addr0(addr0), .stby(sr_stby)
   );

   activity_det #(.MON_W(MON_W)) u_act (
      .clk(clk), .rst(rst), .mon_in(mon_in), .quiet(quiet)
   );

   assign eprom_stby_even = ep_stby.even;
   assign eprom_stby_odd  = ep_stby.odd;
   assign sram_stby_even  = sr_stby.even;
   assign sram_stby_odd   = sr_stby.odd;
   assign pla_zero_pwr    = turbo_off;
   assign pdown           = chip_en && turbo_off && quiet;

   AST_PDOWN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      pdown |-> (!cs_n || cs_pin_is_addr)); // R11
   AST_PDOWN_NEEDS_TURBO_OFF: assert property (@(posedge clk) disable iff (rst)
      pdown |-> pla_zero_pwr); // R11
   AST_ADDR_MODE_ENABLED: assert property (@(posedge clk) disable iff (rst)
      (cs_pin_is_addr && !miser_on) |-> !(eprom_stby_even || eprom_stby_odd)); // R10
endmodule

// File: tb/sim_mem_logic_pwr_ctl.sv
module sim_mem_logic_pwr_ctl;
   localparam logic [7:0] PWR_OFF = 8'h10;
   localparam logic [7:0] CFG_OFF = 8'h12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic io_sel = 0, io_wr = 0, io_rd = 0;
   logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
   logic cs_n = 0, cs_pin_is_addr = 0, eprom_sel = 0, sram_sel = 0;
   logic byte_mode = 0, addr0 = 0;
   logic [15:0] mon_in = 16'h1234;
   logic eprom_stby_even, eprom_stby_odd, sram_stby_even, sram_stby_odd;
   logic pla_zero_pwr, pdown;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   mem_logic_pwr_ctl u0 (
      .clk(clk), .rst(rst), .io_sel(io_sel), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cs_n(cs_n), .cs_pin_is_addr(cs_pin_is_addr), .eprom_sel(eprom_sel),
      .sram_sel(sram_sel), .byte_mode(byte_mode), .addr0(addr0), .mon_in(mon_in),
      .eprom_stby_even(eprom_stby_even), .eprom_stby_odd(eprom_stby_odd),
      .sram_stby_even(sram_stby_even), .sram_stby_odd(sram_stby_odd),
      .pla_zero_pwr(pla_zero_pwr), .pdown(pdown)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic sel);
      @(negedge clk);
      io_sel = sel; io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk);
      io_sel = 0; io_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_sel = 1; io_addr = a; io_rd = 1;
      #1 d = io_rdata;
      io_sel = 0; io_rd = 0;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   function automatic logic [3:0] stby4();
      return {eprom_stby_even, eprom_stby_odd, sram_stby_even, sram_stby_odd};
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      rd(PWR_OFF, d); chk("R1 pmr after reset", d, 8'hFE);
      rd(CFG_OFF, d); chk("R1 cfg after reset", d, 8'h00);
      chk("R9 turbo on after reset", pla_zero_pwr, 1'b0);
      @(negedge clk); #1 chk("R12 idle rdata", io_rdata, 8'h00);
   endtask

   task automatic t_turbo();
      logic [7:0] d;
      wr(PWR_OFF, 8'h01, 1'b1);
      rd(PWR_OFF, d); chk("R2 pmr turbo off readback", d, 8'hFF);
      chk("R9 zero power while turbo off", pla_zero_pwr, 1'b1);
      wr(PWR_OFF, 8'h00, 1'b1);
      rd(PWR_OFF, d); chk("R2 pmr reserved read 1", d, 8'hFE);
      chk("R9 high speed while turbo on", pla_zero_pwr, 1'b0);
   endtask

   task automatic t_cfg();
      logic [7:0] d;
      wr(CFG_OFF, 8'hFF, 1'b1);
      rd(CFG_OFF, d); chk("R3 cfg holds only miser", d, 8'h08);
      wr(8'h11, 8'h00, 1'b1);
      rd(CFG_OFF, d); chk("R3 write to other offset ignored", d, 8'h08);
      wr(CFG_OFF, 8'h00, 1'b0);
      rd(CFG_OFF, d); chk("R3 write without io_sel ignored", d, 8'h08);
      wr(PWR_OFF, 8'h01, 1'b0);
      rd(PWR_OFF, d); chk("R3 pmr write without io_sel ignored", d, 8'hFE);
      rd(8'h11, d); chk("R12 unmapped read", d, 8'h00);
      wr(CFG_OFF, 8'h00, 1'b1);
   endtask

   task automatic t_chip_disable();
      cs_n = 1; eprom_sel = 1; sram_sel = 1;
      settle(); chk("R4 disabled miser off", stby4(), 4'b1111);
      wr(CFG_OFF, 8'h08, 1'b1);
      settle(); chk("R4 disabled miser on", stby4(), 4'b1111);
      cs_pin_is_addr = 1; byte_mode = 0;
      settle(); chk("R10 address mode ignores cs_n", stby4(), 4'b0000);
      wr(CFG_OFF, 8'h00, 1'b1);
      eprom_sel = 0; sram_sel = 0;
      settle(); chk("R10 address mode eprom powered miser off", stby4(), 4'b0011);
      cs_pin_is_addr = 0; cs_n = 0;
   endtask

   task automatic t_miser_off();
      eprom_sel = 0; sram_sel = 1; byte_mode = 1;
      settle(); chk("R5 eprom powered unselected", stby4(), 4'b0000);
      eprom_sel = 1; sram_sel = 0;
      settle(); chk("R5 eprom powered selected byte", stby4(), 4'b0011);
      chk("R8 sram idle standby", {sram_stby_even, sram_stby_odd}, 2'b11);
   endtask

   task automatic t_miser_on();
      wr(CFG_OFF, 8'h08, 1'b1);
      eprom_sel = 0; sram_sel = 1; byte_mode = 0;
      settle(); chk("R6 eprom standby during sram access", stby4(), 4'b1100);
      eprom_sel = 1; sram_sel = 0;
      settle(); chk("R7 word mode both halves", stby4(), 4'b0011);
      byte_mode = 1; addr0 = 0;
      settle(); chk("R7 byte mode even half", stby4(), 4'b0111);
      addr0 = 1;
      settle(); chk("R7 byte mode odd half", stby4(), 4'b1011);
      eprom_sel = 0; sram_sel = 1; addr0 = 0;
      settle(); chk("R8 sram byte even half", stby4(), 4'b1101);
      addr0 = 1;
      settle(); chk("R8 sram byte odd half", stby4(), 4'b1110);
      byte_mode = 0;
      settle(); chk("R8 sram word both halves", stby4(), 4'b1100);
      sram_sel = 0; eprom_sel = 0;
      wr(CFG_OFF, 8'h00, 1'b1);
   endtask

   task automatic t_pdown();
      settle(); chk("R11 no pdown with turbo on", pdown, 1'b0);
      wr(PWR_OFF, 8'h01, 1'b1);
      settle(); chk("R11 pdown when quiet", pdown, 1'b1);
      @(negedge clk); mon_in = mon_in ^ 16'h0100;
      #1 chk("R11 change clears pdown", pdown, 1'b0);
      settle(); chk("R11 pdown returns next cycle", pdown, 1'b1);
      cs_n = 1;
      settle(); chk("R11 no pdown when disabled", pdown, 1'b0);
      cs_pin_is_addr = 1;
      settle(); chk("R10 pdown in address mode", pdown, 1'b1);
      cs_pin_is_addr = 0; cs_n = 0;
      wr(PWR_OFF, 8'h00, 1'b1);
      settle(); chk("R11 turbo on clears pdown", pdown, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_turbo();
      t_cfg();
      t_chip_disable();
      t_miser_off();
      t_miser_on();
      t_pdown();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 20000);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule